// File: doc/BRIEF.md
# Cross-Bus Signal Interrupt Register

This block is a two-bit doorbell register shared between a remote bus and a local processor. A master on the remote bus can raise either of two signal bits: a low-priority bit and a high-priority bit. A raised bit asks the local processor for an interrupt at a fixed level, level 1 for the low-priority bit and level 5 for the high-priority bit. Only the remote side can raise a bit. Only the local side can lower it, by writing a 1 to it. A request therefore stays up until the local processor has seen it and acknowledged it.

The same local read word also shows a board-fail status. The board-fail line is driven when local logic flags a failure or when an external watchdog reports a timeout. The status bit shows the state of that line. Each interrupt has its own enable input. The enable gates only the request and never the stored bit. The block also gives an encoded level output, which names the highest active request.

Top module: `xbus_sig_irq`

## Requirements
- R1: After reset both signal bits read 0, both requests are low, and the encoded level is 0.
- R2: A remote write with data bit 0 (low-priority) or data bit 1 (high-priority) at 1 sets that signal bit at the next clock edge. A remote write of 0 to a bit leaves it unchanged, so the remote side cannot clear.
- R3: A local write with a data bit at 1 clears that signal bit at the next clock edge. A local write of 0 leaves the bit unchanged, so the local side cannot set.
- R4: When a remote set and a local clear hit the same bit in the same cycle, the bit ends up set.
- R5: The low-priority request equals the low-priority bit ANDed with its enable. When it is the only active request, the encoded level reads 1.
- R6: The high-priority request equals the high-priority bit ANDed with its enable. When it is active, the encoded level reads 5, even if the low-priority request is also active.
- R7: Clearing an enable masks the request but leaves the stored bit unchanged. The stored bit stays visible in the local read word: bit 0 is the low-priority bit and bit 1 is the high-priority bit.
- R8: A set signal bit, and with it an enabled request, stays asserted for any number of cycles until a local write of 1 clears it.
- R9: The fail line drive is active whenever the local fail input or the watchdog timeout input is active. Local read word bit 2 and the fail status output read 1 exactly then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rmt_wr | input | 1 | Remote write strobe |
| rmt_wdata | input | 2 | Remote write data, 1 sets (bit 0 low, bit 1 high) |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 2 | Local write data, 1 clears (bit 0 low, bit 1 high) |
| loc_rdata | output | 3 | Local read word {fail status, high bit, low bit} |
| en_lo | input | 1 | Low-priority interrupt enable |
| en_hi | input | 1 | High-priority interrupt enable |
| fail_in | input | 1 | Local logic flags a board failure |
| wdog_to | input | 1 | Watchdog timeout indication |
| irq_lo | output | 1 | Level 1 interrupt request |
| irq_hi | output | 1 | Level 5 interrupt request |
| irq_level | output | 3 | Encoded level of the highest active request, 0 if none |
| fail_stat | output | 1 | Board-fail status |
| fail_drive | output | 1 | Drive for the board-fail line |

## Verification
The hardest situation to reach is a remote set and a local clear that hit the same bit in the same cycle. The case is hardest when the bit is already set, because then the outcome cannot be told apart from plain holding unless it is checked against a model. A directed sequence sets a bit, lets it sit, and then issues both writes at once. Random stimulus then drives both write strobes often enough that overlapping set and clear cycles recur many times, with enables and fail inputs toggling independently of them.

// File: rtl/xbus_sig_irq.sv
module xbus_sig_irq #(
  parameter int LVL_W  = 3,
  parameter int LVL_LO = 1,
  parameter int LVL_HI = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rmt_wr,
  input  logic [1:0]       rmt_wdata,
  input  logic             loc_wr,
  input  logic [1:0]       loc_wdata,
  output logic [2:0]       loc_rdata,
  input  logic             en_lo,
  input  logic             en_hi,
  input  logic             fail_in,
  input  logic             wdog_to,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic [LVL_W-1:0] irq_level,
  output logic             fail_stat,
  output logic             fail_drive
);

  localparam logic [LVL_W-1:0] LO_CODE = LVL_W'(LVL_LO);
  localparam logic [LVL_W-1:0] HI_CODE = LVL_W'(LVL_HI);

  logic [1:0] sig_q;
  wire  [1:0] set_v = rmt_wr ? rmt_wdata : 2'b00;
  wire  [1:0] clr_v = loc_wr ? loc_wdata : 2'b00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sig_q <= 2'b00;
    else        sig_q <= (sig_q & ~clr_v) | set_v;

  assign irq_lo     = sig_q[0] & en_lo;
  assign irq_hi     = sig_q[1] & en_hi;
  assign irq_level  = irq_hi ? HI_CODE : (irq_lo ? LO_CODE : '0);
  assign fail_drive = fail_in | wdog_to;
  assign fail_stat  = fail_drive;
  assign loc_rdata  = {fail_stat, sig_q};

  for (genvar i = 0; i < 2; i++) begin : g_chk
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rmt_wr && rmt_wdata[i]) |=> sig_q[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr && loc_wdata[i] && !(rmt_wr && rmt_wdata[i])) |=> !sig_q[i]);
    p_no_local_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sig_q[i] && !(rmt_wr && rmt_wdata[i])) |=> !sig_q[i]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_q[i] && !(loc_wr && loc_wdata[i])) |=> sig_q[i]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rmt_wr && rmt_wdata[i] && loc_wr && loc_wdata[i]) |=> sig_q[i]);
  end

  p_mask_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lo |-> !irq_lo);
  p_level_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !irq_hi) |-> irq_level == LO_CODE);
  p_level_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> irq_level == HI_CODE);
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_lo && !irq_hi) |-> irq_level == '0);
  p_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_in || wdog_to) |-> (fail_stat && loc_rdata[2]));

endmodule

// File: tb/xbus_sig_irq_bench.sv
module xbus_sig_irq_bench;
  logic clk = 0, rst_n = 0;
  logic rmt_wr = 0, loc_wr = 0, en_lo = 0, en_hi = 0, fail_in = 0, wdog_to = 0;
  logic [1:0] rmt_wdata = 0, loc_wdata = 0;
  logic [2:0] loc_rdata, irq_level;
  logic irq_lo, irq_hi, fail_stat, fail_drive;
  int checks = 0, errors = 0;
  logic [1:0] exp_q = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xbus_sig_irq u_xbus_sig_irq (.clk, .rst_n, .rmt_wr, .rmt_wdata, .loc_wr,
    .loc_wdata, .loc_rdata, .en_lo, .en_hi, .fail_in, .wdog_to, .irq_lo,
    .irq_hi, .irq_level, .fail_stat, .fail_drive);

  function automatic int exp_level(logic [1:0] q, logic el, logic eh);
    if (q[1] && eh) return 5;
    if (q[0] && el) return 1;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R7 stored bits"}, loc_rdata[1:0], exp_q);
    chk({tag, " R5 irq_lo"}, irq_lo, exp_q[0] & en_lo);
    chk({tag, " R6 irq_hi"}, irq_hi, exp_q[1] & en_hi);
    chk({tag, " R6 level"}, irq_level, exp_level(exp_q, en_lo, en_hi));
    chk({tag, " R9 fail_stat"}, {fail_stat, loc_rdata[2]}, {2{fail_in | wdog_to}});
    chk({tag, " R9 fail_drive"}, fail_drive, fail_in | wdog_to);
  endtask

  task automatic step(logic rw, logic [1:0] rd, logic lw, logic [1:0] ld, string tag);
    @(negedge clk);
    rmt_wr = rw; rmt_wdata = rd; loc_wr = lw; loc_wdata = ld;
    @(posedge clk);
    exp_q = (exp_q & ~(lw ? ld : 2'b00)) | (rw ? rd : 2'b00);
    #1;
    check_all(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51C0));
    #5;
    check_all("R1 reset");
    rst_n = 1;
    en_lo = 1; en_hi = 1;
    step(0, 2'b00, 0, 2'b00, "R1 idle");
    step(1, 2'b01, 0, 2'b00, "R2 set lo");
    step(1, 2'b00, 0, 2'b00, "R2 remote zero");
    step(0, 2'b00, 1, 2'b10, "R3 clr other");
    step(1, 2'b10, 0, 2'b00, "R6 both");
    for (int i = 0; i < 20; i++) step(0, 2'b00, 0, 2'b00, "R8 hold");
    step(0, 2'b00, 1, 2'b00, "R3 local zero");
    @(negedge clk); en_hi = 0; en_lo = 0; #1; check_all("R7 mask");
    @(negedge clk); en_hi = 1; en_lo = 1; #1; check_all("R7 unmask");
    step(1, 2'b11, 1, 2'b11, "R4 set wins");
    step(0, 2'b00, 1, 2'b10, "R3 clr hi");
    step(0, 2'b00, 1, 2'b01, "R3 clr lo");
    step(0, 2'b00, 1, 2'b11, "R3 no local set");
    step(1, 2'b01, 1, 2'b01, "R4 set wins empty");
    @(negedge clk); wdog_to = 1; #1; check_all("R9 watchdog");
    @(negedge clk); wdog_to = 0; fail_in = 1; #1; check_all("R9 local fail");
    @(negedge clk); fail_in = 0; #1; check_all("R9 clear");
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      en_lo = 1'($urandom); en_hi = 1'($urandom);
      fail_in = ($urandom % 8) == 0; wdog_to = ($urandom % 8) == 0;
      step(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), "R2 R3 R4 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule